// File: doc/BRIEF.md
# Programmable Output Logic Cell

This block is one output cell of a small programmable logic array. It takes a sum-of-products result (`sop`) and an input bus. Four product terms are built from the bus under static mask configuration: a clock/enable term, an asynchronous clear term, an asynchronous set term and a pin-enable term. The cell's storage element is set up as a plain combinatorial path, an edge-triggered D flip-flop or a level-sensitive transparent latch. The stored or combinatorial value can be inverted before it reaches the pin and the internal return path.

The clock (or latch enable) is one of four sources: the global clock pin or the cell's own clock term, each in either polarity. The clear and set terms belong to this cell alone, so the cell can be initialized without touching any neighbour. The cell value always returns to the internal routing as `cell_fb`, whatever the pin buffer does, so the cell can also hold buried logic. The pin is modelled as a driven value plus a drive enable. The resolved pin level comes back as `pin_fb` in every mode. All configuration inputs are static and all pins are plain levels, so no stream handshake applies.

Top module: `olc_cell`

## Requirements
- R1: A product term is 1 when every bus bit selected by its true mask is 1 and every bus bit selected by its complement mask is 0. An all-zero mask pair gives 1. A bit set in both masks forces the term to 0.
- R2: `cfg_ensel` selects the clock/enable: 0 = `gclk`, 1 = inverted `gclk`, 2 = clock term, 3 = inverted clock term.
- R3: In D flip-flop mode (`cfg_mode`=1), the cell value takes `sop` only on a rising edge of the selected clock and holds it otherwise.
- R4: In latch mode (`cfg_mode`=2), the cell value follows `sop` while the selected enable is 1 and holds while it is 0.
- R5: In combinatorial mode (`cfg_mode`=0 or 3), the cell value follows `sop`, and the clear and set terms have no effect.
- R6: In a storage mode, clear term 0 with set term 1 forces the stored value to 1 at once, with no clock.
- R7: In a storage mode, clear term 1 forces the stored value to 0 at once, whatever the set term.
- R8: With `cfg_invert`=1, the value on `pad_o` and `cell_fb` is the inverse of the stored or combinatorial value.
- R9: `cell_fb` carries the cell value whatever the pin-enable term.
- R10: `pad_oe` equals the pin-enable term, and `pad_o` carries the cell value even while the pin is not driven.
- R11: `pin_fb` equals `pad_o` while `pad_oe` is 1 and equals the external level `pad_i` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock / latch-enable pin |
| sop | input | 1 | Sum-of-products data into the cell |
| in_bus | input | N_IN | Bus from which the product terms are formed |
| ck_true | input | N_IN | Clock term true mask |
| ck_cmpl | input | N_IN | Clock term complement mask |
| rs_true | input | N_IN | Clear term true mask |
| rs_cmpl | input | N_IN | Clear term complement mask |
| ps_true | input | N_IN | Set term true mask |
| ps_cmpl | input | N_IN | Set term complement mask |
| oe_true | input | N_IN | Pin-enable term true mask |
| oe_cmpl | input | N_IN | Pin-enable term complement mask |
| cfg_mode | input | 2 | 0/3 combinatorial, 1 flip-flop, 2 latch |
| cfg_ensel | input | 2 | Clock/enable source select |
| cfg_invert | input | 1 | Output polarity invert |
| pad_i | input | 1 | External level seen on the pin when not driven |
| pad_o | output | 1 | Value the pin driver presents |
| pad_oe | output | 1 | Pin driver enable |
| pin_fb | output | 1 | Resolved pin level back to routing |
| cell_fb | output | 1 | Cell value back to routing |

## Verification
The checker watches, at every global clock edge, the forced levels under clear and set, the combinatorial pass-through, latch transparency and flip-flop capture when the global pin is the source, and the pin-level resolution. Capture on the inverted global pin and on the clock term in either polarity is asynchronous to the checker's sampling clock, so only the bench scenarios show it. The same holds for product-term decoding across mask patterns, the polarity invert, and the latch hold when its enable falls.

// File: rtl/olc_pkg.sv
package olc_pkg;
  localparam logic [1:0] MODE_COMB  = 2'd0;
  localparam logic [1:0] MODE_DFF   = 2'd1;
  localparam logic [1:0] MODE_LATCH = 2'd2;

  localparam logic [1:0] SEL_GCLK   = 2'd0;
  localparam logic [1:0] SEL_GCLK_N = 2'd1;
  localparam logic [1:0] SEL_PT     = 2'd2;
  localparam logic [1:0] SEL_PT_N   = 2'd3;

  localparam int NUM_PT = 4;
  localparam int PT_CLK = 0;
  localparam int PT_RST = 1;
  localparam int PT_SET = 2;
  localparam int PT_OE  = 3;
endpackage

// File: rtl/olc_pterm.sv
module olc_pterm #(
  parameter int W = 8
) (
  input  logic [W-1:0] bus,
  input  logic [W-1:0] tmask,
  input  logic [W-1:0] cmask,
  output logic         term
);
  logic [W-1:0] bit_ok;
  always_comb begin
    for (int i = 0; i < W; i++) begin
      bit_ok[i] = (bus[i] | ~tmask[i]) & (~bus[i] | ~cmask[i]);
    end
  end
  assign term = &bit_ok;
endmodule

// File: rtl/olc_ensel.sv
module olc_ensel
  import olc_pkg::*;
(
  input  logic       gclk,
  input  logic       pt_clk,
  input  logic [1:0] sel,
  output logic       en
);
  always_comb begin
    unique case (sel)
      SEL_GCLK:   en = gclk;
      SEL_GCLK_N: en = ~gclk;
      SEL_PT:     en = pt_clk;
      default:    en = ~pt_clk;
    endcase
  end
endmodule

// File: rtl/olc_store.sv
module olc_store
  import olc_pkg::*;
(
  input  logic       d,
  input  logic       en,
  input  logic       clr,
  input  logic       set,
  input  logic [1:0] mode,
  output logic       q
);
  logic q_ff;
  logic q_lat;

  always_ff @(posedge en or posedge clr or posedge set) begin
    if (clr)      q_ff <= 1'b0;
    else if (set) q_ff <= 1'b1;
    else          q_ff <= d;
  end

  always_latch begin
    if (clr)      q_lat = 1'b0;
    else if (set) q_lat = 1'b1;
    else if (en)  q_lat = d;
  end

  always_comb begin
    if (mode == MODE_DFF || mode == MODE_LATCH) begin
      if (clr)      q = 1'b0;
      else if (set) q = 1'b1;
      else          q = (mode == MODE_DFF) ? q_ff : q_lat;
    end else begin
      q = d;
    end
  end
endmodule

// File: rtl/olc_cell.sv
module olc_cell
  import olc_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  logic            gclk,
  input  logic            sop,
  input  logic [N_IN-1:0] in_bus,
  input  logic [N_IN-1:0] ck_true,
  input  logic [N_IN-1:0] ck_cmpl,
  input  logic [N_IN-1:0] rs_true,
  input  logic [N_IN-1:0] rs_cmpl,
  input  logic [N_IN-1:0] ps_true,
  input  logic [N_IN-1:0] ps_cmpl,
  input  logic [N_IN-1:0] oe_true,
  input  logic [N_IN-1:0] oe_cmpl,
  input  logic [1:0]      cfg_mode,
  input  logic [1:0]      cfg_ensel,
  input  logic            cfg_invert,
  input  logic            pad_i,
  output logic            pad_o,
  output logic            pad_oe,
  output logic            pin_fb,
  output logic            cell_fb
);
  logic [NUM_PT-1:0][N_IN-1:0] tm_arr;
  logic [NUM_PT-1:0][N_IN-1:0] cm_arr;
  logic [NUM_PT-1:0]           terms;
  logic                        sel_en;
  logic                        core_q;
  logic                        out_val;

  assign tm_arr[PT_CLK] = ck_true;
  assign cm_arr[PT_CLK] = ck_cmpl;
  assign tm_arr[PT_RST] = rs_true;
  assign cm_arr[PT_RST] = rs_cmpl;
  assign tm_arr[PT_SET] = ps_true;
  assign cm_arr[PT_SET] = ps_cmpl;
  assign tm_arr[PT_OE]  = oe_true;
  assign cm_arr[PT_OE]  = oe_cmpl;

  for (genvar g = 0; g < NUM_PT; g++) begin : g_pt
    olc_pterm #(.W(N_IN)) u_pt (
      .bus   (in_bus),
      .tmask (tm_arr[g]),
      .cmask (cm_arr[g]),
      .term  (terms[g])
    );
  end

  olc_ensel u_ensel (
    .gclk   (gclk),
    .pt_clk (terms[PT_CLK]),
    .sel    (cfg_ensel),
    .en     (sel_en)
  );

  olc_store u_store (
    .d    (sop),
    .en   (sel_en),
    .clr  (terms[PT_RST]),
    .set  (terms[PT_SET]),
    .mode (cfg_mode),
    .q    (core_q)
  );

  assign out_val = core_q ^ cfg_invert;
  assign cell_fb = out_val;
  assign pad_o   = out_val;
  assign pad_oe  = terms[PT_OE];
  assign pin_fb  = pad_oe ? pad_o : pad_i;
endmodule

// File: rtl/olc_cell_chk.sv
module olc_cell_chk
  import olc_pkg::*;
(
  input logic       gclk,
  input logic       sop,
  input logic       clr_t,
  input logic       set_t,
  input logic       en_sel,
  input logic [1:0] cfg_mode,
  input logic [1:0] cfg_ensel,
  input logic       core_q,
  input logic       pad_o,
  input logic       pad_oe,
  input logic       pad_i,
  input logic       pin_fb
);
  logic store_mode;
  assign store_mode = (cfg_mode == MODE_DFF) || (cfg_mode == MODE_LATCH);

  assert_clear_wins_R7: assert property (@(posedge gclk) disable iff (!clr_t)
    store_mode |-> core_q == 1'b0);

  assert_set_forces_R6: assert property (@(posedge gclk) disable iff (clr_t)
    (store_mode && set_t) |-> core_q == 1'b1);

  assert_comb_pass_R5: assert property (@(posedge gclk) disable iff (1'b0)
    (cfg_mode == MODE_COMB || cfg_mode == 2'd3) |-> core_q == sop);

  assert_latch_open_R4: assert property (@(posedge gclk) disable iff (clr_t || set_t)
    (cfg_mode == MODE_LATCH && en_sel) |-> core_q == sop);

  assert_ff_capture_R3: assert property (@(posedge gclk) disable iff (clr_t || set_t)
    (cfg_mode == MODE_DFF && cfg_ensel == SEL_GCLK) ##1
    (cfg_mode == MODE_DFF && cfg_ensel == SEL_GCLK) |-> core_q == $past(sop));

  assert_pin_level_R11: assert property (@(posedge gclk) disable iff (1'b0)
    pin_fb == (pad_oe ? pad_o : pad_i));
endmodule

bind olc_cell olc_cell_chk u_chk (
  .gclk      (gclk),
  .sop       (sop),
  .clr_t     (terms[olc_pkg::PT_RST]),
  .set_t     (terms[olc_pkg::PT_SET]),
  .en_sel    (sel_en),
  .cfg_mode  (cfg_mode),
  .cfg_ensel (cfg_ensel),
  .core_q    (core_q),
  .pad_o     (pad_o),
  .pad_oe    (pad_oe),
  .pad_i     (pad_i),
  .pin_fb    (pin_fb)
);

// File: tb/olc_cell_bench.sv
module olc_cell_bench;
  localparam int N = 8;

  logic         gclk = 1'b0;
  logic         sop = 1'b0;
  logic [N-1:0] in_bus = '0;
  logic [N-1:0] ck_true = '0, ck_cmpl = '0;
  logic [N-1:0] rs_true = '0, rs_cmpl = '0;
  logic [N-1:0] ps_true = 8'h80, ps_cmpl = 8'h80;
  logic [N-1:0] oe_true = '0, oe_cmpl = '0;
  logic [1:0]   cfg_mode = 2'd1;
  logic [1:0]   cfg_ensel = 2'd0;
  logic         cfg_invert = 1'b0;
  logic         pad_i = 1'b0;
  logic         pad_o, pad_oe, pin_fb, cell_fb;

  int n_run = 0;
  int n_fail = 0;

  olc_cell #(.N_IN(N)) u_olc_cell (
    .gclk(gclk), .sop(sop), .in_bus(in_bus),
    .ck_true(ck_true), .ck_cmpl(ck_cmpl),
    .rs_true(rs_true), .rs_cmpl(rs_cmpl),
    .ps_true(ps_true), .ps_cmpl(ps_cmpl),
    .oe_true(oe_true), .oe_cmpl(oe_cmpl),
    .cfg_mode(cfg_mode), .cfg_ensel(cfg_ensel), .cfg_invert(cfg_invert),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .pin_fb(pin_fb), .cell_fb(cell_fb)
  );

  always #2 gclk = ~gclk;

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // bus, oe true mask, oe complement mask, sop, invert, expected oe, expected value
  typedef struct packed {
    logic [7:0] bus;
    logic [7:0] tm;
    logic [7:0] cm;
    logic       d;
    logic       inv;
    logic       e_oe;
    logic       e_out;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'h05, 8'h05, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'h04, 8'h05, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'hF0, 8'h00, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'hF1, 8'h00, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'hA5, 8'hA0, 8'h0A, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'hA5, 8'h80, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h3C, 8'h3C, 8'hC3, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    // reset state: clear term empty masks -> 1, flip-flop mode
    #1;
    check("R7 reset state pad_o", pad_o, 1'b0);
    check("R10 oe empty mask", pad_oe, 1'b1);
    @(negedge gclk);
    ps_true = '0; ps_cmpl = '0;  // set term 1 too
    #1 check("R7 clear beats set", pad_o, 1'b0);
    @(negedge gclk);
    rs_true = 8'h80; rs_cmpl = 8'h80;  // clear term forced 0
    #1 check("R6 set alone forces 1", pad_o, 1'b1);
    check("R1 both masks force 0 (clear off)", pad_o, 1'b1);

    // table of combinatorial vectors (R1, R5, R8, R11)
    @(negedge gclk);
    ps_true = 8'h80; ps_cmpl = 8'h80;
    cfg_mode = 2'd0;
    for (int i = 0; i < 8; i++) begin
      @(negedge gclk);
      in_bus = VECS[i].bus; oe_true = VECS[i].tm; oe_cmpl = VECS[i].cm;
      sop = VECS[i].d; cfg_invert = VECS[i].inv; pad_i = ~VECS[i].e_out;
      #1;
      check($sformatf("R1 vec %0d oe term", i), pad_oe, VECS[i].e_oe);
      check($sformatf("R8 vec %0d value", i), pad_o, VECS[i].e_out);
      check($sformatf("R11 vec %0d pin level", i), pin_fb,
            VECS[i].e_oe ? VECS[i].e_out : ~VECS[i].e_out);
    end

    // flip-flop on global clock (R3, R2)
    @(negedge gclk);
    in_bus = '0; oe_true = '0; oe_cmpl = '0; cfg_invert = 1'b0;
    cfg_mode = 2'd1; cfg_ensel = 2'd0; sop = 1'b0;
    @(posedge gclk); #1 check("R3 capture 0", pad_o, 1'b0);
    @(negedge gclk); sop = 1'b1;
    #1 check("R3 hold before edge", pad_o, 1'b0);
    @(posedge gclk); #1 check("R3 capture on rising edge", pad_o, 1'b1);

    // inverted global clock: capture on falling edge
    cfg_ensel = 2'd1; sop = 1'b0;
    #0.5 check("R2 inverted gclk no capture at rise", pad_o, 1'b1);
    @(negedge gclk); #1 check("R2 inverted gclk captures at fall", pad_o, 1'b0);

    // clock from product term, bit 0 true
    ck_true = 8'h01; cfg_ensel = 2'd2; sop = 1'b1;
    #1 check("R2 term clock idle", pad_o, 1'b0);
    in_bus[0] = 1'b1;
    #1 check("R2 term clock rising captures", pad_o, 1'b1);
    cfg_ensel = 2'd3;
    #1 sop = 1'b0;
    #1 check("R2 inverted term no edge yet", pad_o, 1'b1);
    in_bus[0] = 1'b0;
    #1 check("R2 inverted term captures", pad_o, 1'b0);

    // latch on term enable (R4)
    @(negedge gclk);
    cfg_mode = 2'd2; cfg_ensel = 2'd2; in_bus[0] = 1'b1; sop = 1'b1;
    #1 check("R4 latch open follows 1", pad_o, 1'b1);
    sop = 1'b0;
    #1 check("R4 latch open follows 0", pad_o, 1'b0);
    in_bus[0] = 1'b0;
    #1 sop = 1'b1;
    #1 check("R4 latch closed holds", pad_o, 1'b0);
    in_bus[0] = 1'b1;
    #1 check("R4 latch reopens", pad_o, 1'b1);

    // combinatorial ignores clear/set (R5)
    @(negedge gclk);
    cfg_mode = 2'd0; rs_true = '0; rs_cmpl = '0; sop = 1'b1;
    #1 check("R5 comb ignores clear", pad_o, 1'b1);
    @(negedge gclk);
    rs_true = 8'h80; rs_cmpl = 8'h80; ps_true = '0; ps_cmpl = '0; sop = 1'b0;
    #1 check("R5 comb ignores set", pad_o, 1'b0);
    @(negedge gclk);
    ps_true = 8'h80; ps_cmpl = 8'h80; cfg_mode = 2'd3; sop = 1'b1;
    #1 check("R5 mode 3 is comb", pad_o, 1'b1);

    // polarity and feedback with pin disabled (R8, R9, R10, R11)
    @(negedge gclk);
    cfg_invert = 1'b1;
    #1 check("R8 invert pad_o", pad_o, 1'b0);
    check("R8 invert cell_fb", cell_fb, 1'b0);
    @(negedge gclk);
    cfg_invert = 1'b0; oe_true = 8'h80; oe_cmpl = 8'h80; pad_i = 1'b0;
    #1 check("R10 pin disabled", pad_oe, 1'b0);
    check("R9 feedback with pin off", cell_fb, 1'b1);
    check("R10 pad_o holds value when off", pad_o, 1'b1);
    check("R11 pin level from outside 0", pin_fb, 1'b0);
    pad_i = 1'b1; sop = 1'b0;
    #1 check("R11 pin level from outside 1", pin_fb, 1'b1);
    check("R9 feedback follows 0", cell_fb, 1'b0);

    @(negedge gclk);
    summary();
  end
endmodule